// File: doc/BRIEF.md
# SHA-256 Message Schedule Generator

This block expands one 512-bit message block into the 64 schedule words that a SHA-256 compression pass consumes. Sixteen 32-bit message words enter over a valid/ready input. Each one is forwarded unchanged as schedule words 0 to 15. Words 16 to 63 are then derived one at a time and streamed out in strictly increasing order over a valid/ready output that carries the word and its 6-bit position.

Only sixteen words are stored, in a ring. Word i sits in slot i mod 16. Each new word is written over the slot that held the word sixteen positions back, after that word has been read as an operand. The consumer therefore sees four back-to-back groups of sixteen words and never needs random access. A one-cycle completion pulse follows acceptance of the last word, and the block is then ready for the next message block.

Top module: `sha_sched_gen`

## Requirements
- R1: While reset is applied and on the first cycle after its release, out_valid and done are low and in_ready is high.
- R2: Schedule words 0 to 15 equal the input words in the order they were accepted, and carry out_index 0 to 15.
- R3: Each word 16 to 63 equals s1(W[i-2]) + W[i-7] + s0(W[i-15]) + W[i-16], where the sum is taken modulo 2^32, s0(x) = ROTR7(x) ^ ROTR18(x) ^ SHR3(x) and s1(x) = ROTR17(x) ^ ROTR19(x) ^ SHR10(x).
- R4: Within one block, out_index on the accepted words runs 0, 1, ..., 63. Each index appears exactly once and each accepted word's index is one above the previous one.
- R5: While out_valid is high and out_ready is low, out_valid stays high and out_data and out_index keep their values.
- R6: From the cycle after the sixteenth input word is accepted until word 63 has been accepted, in_ready is low.
- R7: done is high for exactly one cycle: the cycle after word 63 is accepted. It is low at all other times.
- R8: Successive blocks are independent. A block's output depends only on its own sixteen input words, not on earlier blocks or earlier stall patterns.
- R9: With out_ready held high, the derived words leave at one per cycle: word 63 is accepted 47 cycles after word 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Input word is present |
| in_ready | output | 1 | Block can take an input word this cycle |
| in_data | input | 32 | Message word, first word first |
| out_valid | output | 1 | Schedule word is present |
| out_ready | input | 1 | Consumer takes the word this cycle |
| out_data | output | 32 | Schedule word |
| out_index | output | 6 | Position of out_data in the 64-word schedule |
| done | output | 1 | One-cycle pulse after word 63 is accepted |

## Verification
A wrong slot offset or a ring slot that is overwritten too early does not show while words 0 to 15 pass through. It shows as a wrong out_data on the first derived word that reads the bad slot, at most 16 words into the derived phase. A stepping fault in the position counter shows at once, as a skipped or repeated out_index or as in_ready rising too early. A fault in the handshake shows as changed data during a stall on the next stalled cycle. The bench therefore checks every accepted word against a behavioural model. It does this with a full-rate consumer and with a randomly stalling one, and over consecutive blocks, so that state left over from the previous block would be caught.

// File: rtl/sha_sched_pkg.sv
package sha_sched_pkg;
  localparam int WORD_W = 32;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [1:0] {
    PH_LOAD  = 2'd0,
    PH_GEN   = 2'd1,
    PH_DRAIN = 2'd2
  } phase_t;

  function automatic word_t rotr(input word_t x, input int n);
    return (x >> n) | (x << (WORD_W - n));
  endfunction

  function automatic word_t small_s0(input word_t x);
    return rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
  endfunction

  function automatic word_t small_s1(input word_t x);
    return rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
  endfunction
endpackage

// File: rtl/sched_ring.sv
module sched_ring
  import sha_sched_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] cur_slot,
  input  word_t         wr_data,
  output word_t         rd_back16,
  output word_t         rd_back15,
  output word_t         rd_back7,
  output word_t         rd_back2
);
  localparam logic [AW-1:0] OFF15 = AW'(1);
  localparam logic [AW-1:0] OFF7  = AW'(DEPTH - 7);
  localparam logic [AW-1:0] OFF2  = AW'(DEPTH - 2);

  word_t slot_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic slot_en;
    assign slot_en = wr_en && (cur_slot == AW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       slot_q[g] <= '0;
      else if (slot_en) slot_q[g] <= wr_data;
    end
  end

  logic [AW-1:0] a15, a7, a2;
  always_comb begin
    a15 = cur_slot + OFF15;
    a7  = cur_slot + OFF7;
    a2  = cur_slot + OFF2;
  end

  assign rd_back16 = slot_q[cur_slot];
  assign rd_back15 = slot_q[a15];
  assign rd_back7  = slot_q[a7];
  assign rd_back2  = slot_q[a2];
endmodule

// File: rtl/sched_mix.sv
module sched_mix
  import sha_sched_pkg::*;
(
  input  word_t w16,
  input  word_t w15,
  input  word_t w7,
  input  word_t w2,
  output word_t w_new
);
  word_t part_a, part_b;
  always_comb begin
    part_a = small_s0(w15) + w16;
    part_b = small_s1(w2) + w7;
    w_new  = part_a + part_b;
  end
endmodule

// File: rtl/sched_ctrl.sv
module sched_ctrl
  import sha_sched_pkg::*;
#(
  parameter int RING  = 16,
  parameter int TOTAL = 64,
  localparam int IW = $clog2(TOTAL)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          out_ready,
  output logic          in_ready,
  output logic          take_in,
  output logic          take_gen,
  output logic [IW-1:0] pos,
  output logic          out_valid,
  output logic [IW-1:0] out_index,
  output logic          done
);
  phase_t        phase_q, phase_d;
  logic [IW-1:0] pos_q, pos_d, oidx_q, oidx_d;
  logic          ov_q, ov_d, done_q, done_d;
  logic          out_free, out_fire;

  always_comb begin
    out_free = !ov_q || out_ready;
    out_fire = ov_q && out_ready;
    in_ready = (phase_q == PH_LOAD) && out_free;
    take_in  = in_ready && in_valid;
    take_gen = (phase_q == PH_GEN) && out_free;

    phase_d = phase_q;
    pos_d   = pos_q;
    oidx_d  = oidx_q;
    ov_d    = ov_q;
    done_d  = 1'b0;

    if (take_in || take_gen) begin
      ov_d   = 1'b1;
      oidx_d = pos_q;
      pos_d  = pos_q + IW'(1);
      if (take_in && pos_q == IW'(RING - 1))   phase_d = PH_GEN;
      if (take_gen && pos_q == IW'(TOTAL - 1)) phase_d = PH_DRAIN;
    end else if (out_fire) begin
      ov_d = 1'b0;
    end

    if (phase_q == PH_DRAIN && out_fire) begin
      done_d  = 1'b1;
      phase_d = PH_LOAD;
      pos_d   = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_LOAD;
      pos_q   <= '0;
      oidx_q  <= '0;
      ov_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      pos_q   <= pos_d;
      oidx_q  <= oidx_d;
      ov_q    <= ov_d;
      done_q  <= done_d;
    end
  end

  assign pos       = pos_q;
  assign out_valid = ov_q;
  assign out_index = oidx_q;
  assign done      = done_q;

  assert_hold_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ov_q && !out_ready) |=> (ov_q && $stable(oidx_q)));

  assert_index_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_fire |=> (!ov_q || oidx_q == IW'($past(oidx_q) + IW'(1))));

  assert_no_input_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ov_q && oidx_q >= IW'(RING - 1)) |-> !in_ready);

  assert_done_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_fire && oidx_q == IW'(TOTAL - 1)) |=> done_q);

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
endmodule

// File: rtl/sha_sched_gen.sv
module sha_sched_gen
  import sha_sched_pkg::*;
#(
  parameter int RING  = 16,
  parameter int TOTAL = 64,
  localparam int IW = $clog2(TOTAL),
  localparam int AW = $clog2(RING)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic [IW-1:0]     out_index,
  output logic              done
);
  logic          take_in, take_gen;
  logic [IW-1:0] pos;
  word_t         b16, b15, b7, b2, mixed, wr_word, out_q;

  sched_ctrl #(.RING(RING), .TOTAL(TOTAL)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_ready(out_ready),
    .in_ready(in_ready), .take_in(take_in), .take_gen(take_gen), .pos(pos),
    .out_valid(out_valid), .out_index(out_index), .done(done)
  );

  sched_ring #(.DEPTH(RING)) u_ring (
    .clk(clk), .rst_n(rst_n), .wr_en(take_in || take_gen),
    .cur_slot(pos[AW-1:0]), .wr_data(wr_word),
    .rd_back16(b16), .rd_back15(b15), .rd_back7(b7), .rd_back2(b2)
  );

  sched_mix u_mix (.w16(b16), .w15(b15), .w7(b7), .w2(b2), .w_new(mixed));

  always_comb wr_word = take_in ? in_data : mixed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    out_q <= '0;
    else if (take_in || take_gen)  out_q <= wr_word;
  end

  assign out_data = out_q;

  assert_data_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> $stable(out_data));

  assert_first_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (take_in && pos == '0) |=> (out_valid && out_data == $past(in_data)));
endmodule

// File: tb/tb_sha_sched_gen.sv
module tb_sha_sched_gen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready, out_valid, out_ready, done;
  logic [31:0] in_data, out_data;
  logic [5:0]  out_index;

  always #5 clk = ~clk;

  sha_sched_gen dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_index(out_index), .done(done)
  );

  int tests = 0;
  int fails = 0;
  logic [31:0] msg [16];
  logic [31:0] ref_w [64];

  function automatic logic [31:0] rr(input logic [31:0] x, input int n);
    logic [63:0] d;
    d = {x, x} >> n;
    return d[31:0];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic build_ref();
    logic [31:0] q[$];
    for (int i = 0; i < 16; i++) q.push_back(msg[i]);
    for (int i = 16; i < 64; i++) begin
      logic [31:0] a, b;
      a = q[i-15];
      b = q[i-2];
      q.push_back((rr(b,17) ^ rr(b,19) ^ (b >> 10)) + q[i-7] +
                  (rr(a,7) ^ rr(a,18) ^ (a >> 3)) + q[i-16]);
    end
    for (int i = 0; i < 64; i++) ref_w[i] = q[i];
  endtask

  task automatic run_block(input bit stall, output int gap);
    int ld = 0, em = 0, cyc = 0, c16 = 0, c63 = 0;
    bit prev_hold = 0, done_exp = 0, got_done = 0, fire63;
    logic [31:0] prev_d = '0;
    logic [5:0]  prev_i = '0;
    build_ref();
    while (!got_done && cyc < 3000) begin
      @(negedge clk);
      out_ready = stall ? ($urandom_range(0, 2) != 0) : 1'b1;
      in_valid  = (ld < 16) && (stall ? $urandom_range(0, 1) == 1 : 1'b1);
      in_data   = in_valid ? msg[ld] : $urandom;
      #1;
      if (done !== done_exp) chk(0, "R7 done timing", {31'd0, done}, {31'd0, done_exp});
      if (done_exp) begin
        chk(done === 1'b1, "R7 done pulse", {31'd0, done}, 32'd1);
        got_done = 1;
      end
      if (prev_hold)
        chk(out_valid && out_data == prev_d && out_index == prev_i, "R5 stall hold",
            out_data, prev_d);
      if (ld == 16 && em < 64 && in_ready)
        chk(0, "R6 in_ready while busy", {31'd0, in_ready}, 32'd0);
      if (in_valid && in_ready) ld++;
      fire63 = 0;
      if (out_valid && out_ready && em < 64) begin
        chk(out_index == 6'(em), "R4 index order", {26'd0, out_index}, em);
        if (em < 16) chk(out_data === ref_w[em], "R2 passthrough", out_data, ref_w[em]);
        else         chk(out_data === ref_w[em], "R3 derived word", out_data, ref_w[em]);
        if (em == 16) c16 = cyc;
        if (em == 63) begin c63 = cyc; fire63 = 1; end
        em++;
      end
      prev_hold = out_valid && !out_ready;
      prev_d    = out_data;
      prev_i    = out_index;
      done_exp  = fire63;
      cyc++;
    end
    if (!got_done) chk(0, "R7 block never completed", em, 64);
    in_valid = 1'b0;
    gap = c63 - c16;
  endtask

  task automatic load_abc();
    for (int i = 0; i < 16; i++) msg[i] = '0;
    msg[0]  = 32'h6162_6380;
    msg[15] = 32'h0000_0018;
  endtask

  initial begin
    int gap;
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0; in_data = '0;
    repeat (3) @(negedge clk);
    chk(!out_valid && !done && in_ready, "R1 during reset", {29'd0, out_valid, done, in_ready}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && !done && in_ready, "R1 after reset", {29'd0, out_valid, done, in_ready}, 32'd1);

    load_abc();
    run_block(1'b0, gap);
    chk(gap == 47, "R9 full-rate derived words", gap, 47);

    for (int i = 0; i < 16; i++) msg[i] = $urandom;
    run_block(1'b1, gap);

    load_abc();
    run_block(1'b1, gap);

    for (int i = 0; i < 16; i++) msg[i] = 32'hFFFF_FFFF - i;
    run_block(1'b0, gap);
    chk(gap == 47, "R8 R9 back-to-back block rate", gap, 47);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 10);
    tests++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule